// File: doc/BRIEF.md
# Serial Output Bring-Up Write Sequencer

This block powers up a serial video output path by replaying a fixed list of seven register writes toward a serial host-interface master. Nothing is written until software pulses a start request, so the output can stay off when the longest cable reach is wanted. Each write is offered on a valid/ready port and the next write is not offered until the current one has been accepted. The data-lane FIFO control register is written twice in a row with two different values, as two separate transfers. Writes are never reordered or merged.

Besides the bring-up list, the block can issue a single write to a termination-select register. It keeps one bit per output channel in a shadow mask (1 = 50 Ω, 0 = 75 Ω), updates one channel per request, and writes the whole mask. An acknowledge timeout stops the sequence and raises an error. An abort input returns the block to idle at any time. A debug output reports the index of the current step.

Write port rules: `wr_valid_o` is asserted with `wr_addr_o` and `wr_data_o`. While `wr_ready_i` is low, the block holds all three stable. A write completes on a rising clock edge where both valid and ready are high. The master may hold ready low for any number of cycles, which back-pressures the sequence. That stall is bounded only by the timeout. An abort or a timeout can withdraw an offered write.

Top module: `txb_bringup_seq`

## Requirements
- R1: After reset, and for as long as no start or termination request arrives, `wr_valid_o`, `busy_o`, `done_o` and `err_o` are 0, `step_o` is 0, and no write is offered.
- R2: After a start pulse accepted in idle, the block issues exactly seven writes in this order (default addresses in parentheses): driver power-up (0x20) = 0x03, parallel-to-serial clock enable (0x21) = 0x01, word clock enable (0x22) = 0x01, recovered-clock transmit enable (0x23) = 0x01, parallel-to-serial reset release (0x24) = 0x01, lane FIFO control (0x28) = 0x09, lane FIFO control (0x28) = 0x08. The last two are separate transfers.
- R3: While `wr_valid_o` is high and `wr_ready_i` is low, the offered address and data stay unchanged and valid stays high, unless an abort or a timeout occurs. Only one write is outstanding at a time.
- R4: `busy_o` is 1 while a write is pending. `step_o` equals the number of bring-up writes completed in the current run. After the seventh transfer, `busy_o` falls and `done_o` rises, and `done_o` stays high until the next start or abort. `done_o` and `err_o` are never both 1.
- R5: A start pulse while busy is ignored: the running sequence continues and is not restarted.
- R6: With `tmo_limit_i` = L > 0, if a write sees L consecutive cycles offered without ready, the block drops valid, returns to idle and sets `err_o`. It clears `done_o`, and `step_o` keeps the index of the failed step. A stall of L-1 cycles completes normally. L = 0 disables the timeout.
- R7: An abort pulse returns the block to idle on the next edge with valid, busy, done and err at 0 and `step_o` at 0.
- R8: A termination request accepted in idle sets bit `term_chan_i` of the shadow mask to `term_50_i` and issues one write to the termination register (default 0x30) carrying the whole mask in the low bits. The mask resets to all zero.
- R9: A termination request is ignored while busy, and a start in the same cycle as a termination request wins. In both cases the mask is left unchanged.
- R10: A start after completion, error or abort clears `done_o` and `err_o` and replays the list from the first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start bring-up request (pulse) |
| abort_i | input | 1 | Abort and return to idle |
| term_req_i | input | 1 | Termination-select update request |
| term_chan_i | input | CH_W | Channel whose termination changes |
| term_50_i | input | 1 | 1 selects 50 Ω, 0 selects 75 Ω |
| tmo_limit_i | input | TMO_W | Acknowledge timeout in cycles, 0 disables |
| wr_valid_o | output | 1 | Write offered |
| wr_ready_i | input | 1 | Master accepts the write |
| wr_addr_o | output | AW | Register address |
| wr_data_o | output | DW | Register data |
| busy_o | output | 1 | A write is pending |
| done_o | output | 1 | Bring-up list completed |
| err_o | output | 1 | Acknowledge timeout occurred |
| step_o | output | 3 | Completed bring-up steps in the current run |

## Verification
The bring-up list is replayed with the ready stall swept from zero to four cycles per write, with the timeout both disabled and set above the stall. This shows that the order and values do not depend on back-pressure, and that the two FIFO-control writes stay separate. Stalls of exactly L and L-1 cycles on the first, a middle and the last step, for limits 1 to 4, locate the timeout boundary and confirm that the error reports the failed step. Abort mid-run, repeated starts while busy, and starts after errors tell a true restart apart from an ignored request. Every channel/selection pair of termination writes, plus requests blocked by a busy run or a same-cycle start, shows through the written mask which updates took effect.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TERM = 2'd2
  } txb_state_e;
endpackage

// File: rtl/txb_step_table.sv
module txb_step_table
  import txb_pkg::*;
#(
  parameter int unsigned     AW          = 8,
  parameter int unsigned     DW          = 8,
  parameter logic [AW-1:0]   A_DRV_PWR   = 8'h20,
  parameter logic [AW-1:0]   A_P2S_CLK   = 8'h21,
  parameter logic [AW-1:0]   A_WORD_CLK  = 8'h22,
  parameter logic [AW-1:0]   A_RCLK_TX   = 8'h23,
  parameter logic [AW-1:0]   A_P2S_RST   = 8'h24,
  parameter logic [AW-1:0]   A_LANE_FIFO = 8'h28
) (
  input  logic [STEP_W-1:0] idx_i,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     data_o
);
  // Order is behaviour: the lane FIFO register is written twice, 0x09 then 0x08.
  localparam logic [AW-1:0] ADDR_LIST [NUM_STEPS] = '{
    A_DRV_PWR, A_P2S_CLK, A_WORD_CLK, A_RCLK_TX, A_P2S_RST, A_LANE_FIFO, A_LANE_FIFO
  };
  localparam logic [DW-1:0] DATA_LIST [NUM_STEPS] = '{
    DW'(8'h03), DW'(8'h01), DW'(8'h01), DW'(8'h01), DW'(8'h01), DW'(8'h09), DW'(8'h08)
  };

  always_comb begin
    addr_o = '0;
    data_o = '0;
    if (idx_i < STEP_W'(NUM_STEPS)) begin
      addr_o = ADDR_LIST[idx_i];
      data_o = DATA_LIST[idx_i];
    end
  end
endmodule

// File: rtl/txb_ack_timer.sv
module txb_ack_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          fire_o
);
  logic [TW-1:0] cnt_q;

  // cnt_q counts stalled cycles already seen. The limit-th stalled cycle fires.
  assign fire_o = stall_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || !stall_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: a cycle without stall restarts the count
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i) |=> (cnt_q == '0));
  // R6: each stalled cycle that does not fire adds one to the count
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !clear_i && !fire_o && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/txb_term_shadow.sv
module txb_term_shadow #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_i,
  input  logic [CW-1:0]  chan_i,
  input  logic           sel_i,
  output logic [NCH-1:0] mask_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (upd_i && (chan_i == CW'(g))) begin
        bit_q <= sel_i;
      end
    end
    assign mask_o[g] = bit_q;
  end

  // R9: without an accepted update the mask holds
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i) |=> $stable(mask_o));
  // R8: one update touches at most one channel
  p_one_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ($countones(mask_o ^ $past(mask_o)) <= 1));
endmodule

// File: rtl/txb_bringup_seq.sv
module txb_bringup_seq
  import txb_pkg::*;
#(
  parameter int unsigned   AW          = 8,
  parameter int unsigned   DW          = 8,
  parameter int unsigned   NCH         = 4,
  parameter int unsigned   TMO_W       = 8,
  parameter logic [AW-1:0] A_DRV_PWR   = 8'h20,
  parameter logic [AW-1:0] A_P2S_CLK   = 8'h21,
  parameter logic [AW-1:0] A_WORD_CLK  = 8'h22,
  parameter logic [AW-1:0] A_RCLK_TX   = 8'h23,
  parameter logic [AW-1:0] A_P2S_RST   = 8'h24,
  parameter logic [AW-1:0] A_LANE_FIFO = 8'h28,
  parameter logic [AW-1:0] A_TERM_SEL  = 8'h30,
  localparam int unsigned  CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              term_req_i,
  input  logic [CH_W-1:0]   term_chan_i,
  input  logic              term_50_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [STEP_W-1:0] step_o
);
  txb_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, err_q;
  logic              hs, tmo_fire, term_accept, last_step;
  logic [AW-1:0]     tab_addr;
  logic [DW-1:0]     tab_data, term_data;
  logic [NCH-1:0]    term_mask;

  assign hs          = wr_valid_o && wr_ready_i;
  assign last_step   = (step_q == STEP_W'(NUM_STEPS - 1));
  assign term_accept = (state_q == ST_IDLE) && term_req_i && !start_i && !abort_i;

  txb_step_table #(
    .AW(AW), .DW(DW),
    .A_DRV_PWR(A_DRV_PWR), .A_P2S_CLK(A_P2S_CLK), .A_WORD_CLK(A_WORD_CLK),
    .A_RCLK_TX(A_RCLK_TX), .A_P2S_RST(A_P2S_RST), .A_LANE_FIFO(A_LANE_FIFO)
  ) u_table (
    .idx_i (step_q),
    .addr_o(tab_addr),
    .data_o(tab_data)
  );

  txb_ack_timer #(.TW(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall_i(wr_valid_o && !wr_ready_i),
    .clear_i(abort_i),
    .limit_i(tmo_limit_i),
    .fire_o (tmo_fire)
  );

  txb_term_shadow #(.NCH(NCH), .CW(CH_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_i (term_accept),
    .chan_i(term_chan_i),
    .sel_i (term_50_i),
    .mask_o(term_mask)
  );

  always_comb begin
    term_data = '0;
    term_data[NCH-1:0] = term_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
          end else if (term_req_i) begin
            state_q <= ST_TERM;
          end
        end
        ST_RUN: begin
          if (tmo_fire) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            done_q  <= 1'b0;
          end else if (hs) begin
            step_q <= step_q + 1'b1;
            if (last_step) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_TERM: begin
          if (tmo_fire) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            done_q  <= 1'b0;
          end else if (hs) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q != ST_IDLE);
  assign wr_addr_o  = (state_q == ST_TERM) ? A_TERM_SEL : tab_addr;
  assign wr_data_o  = (state_q == ST_TERM) ? term_data  : tab_data;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign step_o     = step_q;

  // R3: a stalled write keeps its address and data
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i && !abort_i && !tmo_fire)
      |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  // R4: each accepted bring-up write advances the step index by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && hs && !abort_i) |=> (step_o == $past(step_o) + 1'b1));
  // R4: completion and error never coexist
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R2: done rises only right after the final FIFO-control write
  p_done_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(hs) && ($past(wr_addr_o) == A_LANE_FIFO)
                       && ($past(wr_data_o) == DW'(8'h08))));
  // R5: a start while busy leaves the sequence running and the step unchanged
  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !abort_i && !hs && !tmo_fire) |=> (busy_o && $stable(step_o)));
  // R6: a timeout halts and flags
  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_fire && !abort_i) |=> (err_o && !wr_valid_o && $stable(step_o)));
  // R7: abort returns to a clean idle
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!wr_valid_o && !busy_o && !done_o && !err_o && (step_o == '0)));
endmodule

// File: tb/txb_bringup_seq_tb_top.sv
module txb_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int TMO_W = 8;
  localparam logic [7:0] A_TERM = 8'h30;

  logic       clk, rst_n, start_i, abort_i, term_req_i, term_50_i;
  logic [1:0] term_chan_i;
  logic [7:0] tmo_limit_i;
  logic       wr_valid_o, wr_ready_i, busy_o, done_o, err_o;
  logic [7:0] wr_addr_o, wr_data_o;
  logic [2:0] step_o;

  int n_cmp = 0, n_bad = 0;
  int log_a[64], log_d[64];
  int log_n = 0, stall_n = 0, stall_only = -1, wcnt = 0;
  int model_mask = 0;
  int ea[7] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h28, 8'h28};
  int ed[7] = '{3, 1, 1, 1, 1, 9, 8};

  txb_bringup_seq #(.NCH(NCH), .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .term_req_i(term_req_i), .term_chan_i(term_chan_i), .term_50_i(term_50_i),
    .tmo_limit_i(tmo_limit_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .step_o(step_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Master model: stalls the chosen writes, logs every write it accepts
  always @(negedge clk) begin : drv
    int lim;
    if (!rst_n || !wr_valid_o) begin
      wr_ready_i = 1'b0;
      wcnt = 0;
    end else begin
      lim = (stall_only < 0 || log_n == stall_only) ? stall_n : 0;
      if (wcnt >= lim) begin
        wr_ready_i = 1'b1;
        if (log_n < 64) begin
          log_a[log_n] = int'(wr_addr_o);
          log_d[log_n] = int'(wr_data_o);
        end
        log_n++;
        wcnt = 0;
      end else begin
        wr_ready_i = 1'b0;
        wcnt++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle;
    int k = 0;
    while (busy_o && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_term(int c, int s);
    log_n = 0;
    term_chan_i = 2'(c);
    term_50_i = 1'(s);
    term_req_i = 1'b1;
    @(negedge clk);
    term_req_i = 1'b0;
    wait_idle();
  endtask

  task automatic full_run_ok(string tag);
    chk({tag, " R2 write count"}, log_n, 7);
    for (int i = 0; i < 7; i++) begin
      chk({tag, " R2 addr"}, log_a[i], ea[i]);
      chk({tag, " R2 data"}, log_d[i], ed[i]);
    end
    chk({tag, " R4 done"}, int'(done_o), 1);
    chk({tag, " R4 err"}, int'(err_o), 0);
    chk({tag, " R4 step"}, int'(step_o), 7);
    chk({tag, " R4 busy"}, int'(busy_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; term_req_i = 1'b0;
    term_chan_i = 2'd0; term_50_i = 1'b0; tmo_limit_i = 8'd0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state and no activity without a request
    chk("R1 valid", int'(wr_valid_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 step", int'(step_o), 0);
    cyc(20);
    chk("R1 no writes", log_n, 0);

    // R2/R3/R4: stall sweep, timeout off and on
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s <= 4; s++) begin
        tmo_limit_i = (t == 0) ? 8'd0 : 8'd5;
        stall_n = s;
        log_n = 0;
        do_start();
        chk("R4 busy during run", int'(busy_o), 1);
        wait_idle();
        full_run_ok("R3 stall sweep");
      end
    end

    // R5: repeated starts while busy
    tmo_limit_i = 8'd0; stall_n = 1; log_n = 0;
    do_start(); cyc(3); do_start(); cyc(2); do_start();
    wait_idle();
    full_run_ok("R5 start while busy");

    // R7: abort clears done
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk("R7 done cleared", int'(done_o), 0);

    // R7 mid-run abort, then R10 restart
    stall_n = 2; log_n = 0;
    do_start();
    for (int k = 0; k < 200 && log_n < 3; k++) @(negedge clk);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk("R7 valid", int'(wr_valid_o), 0);
    chk("R7 busy", int'(busy_o), 0);
    chk("R7 step", int'(step_o), 0);
    cyc(10);
    chk("R7 no further writes", log_n, 3);
    log_n = 0;
    do_start();
    wait_idle();
    full_run_ok("R10 restart after abort");

    // R6: timeout boundary on first, middle, last step
    for (int L = 1; L <= 4; L++) begin
      for (int jj = 0; jj < 3; jj++) begin
        int j;
        j = (jj == 0) ? 0 : ((jj == 1) ? 3 : 6);
        tmo_limit_i = 8'(L);
        stall_only = j;
        stall_n = L;
        log_n = 0;
        do_start();
        chk("R10 err cleared by start", int'(err_o), 0);
        wait_idle();
        chk("R6 err", int'(err_o), 1);
        chk("R6 done", int'(done_o), 0);
        chk("R6 step", int'(step_o), j);
        chk("R6 writes", log_n, j);
        chk("R6 valid", int'(wr_valid_o), 0);
        stall_n = L - 1;
        log_n = 0;
        do_start();
        wait_idle();
        full_run_ok("R6 below limit");
      end
    end
    // R6: limit 0 disables the timeout
    tmo_limit_i = 8'd0; stall_only = 2; stall_n = 40; log_n = 0;
    do_start(); wait_idle();
    full_run_ok("R6 disabled");
    stall_only = -1; stall_n = 0;

    // R8: every channel and selection
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < NCH; c++) begin
        do_term(c, s);
        model_mask = s ? (model_mask | (1 << c)) : (model_mask & ~(1 << c));
        chk("R8 term writes", log_n, 1);
        chk("R8 term addr", log_a[0], int'(A_TERM));
        chk("R8 term mask", log_d[0], model_mask);
      end
    end
    do_term(2, 0);
    model_mask = model_mask & ~(1 << 2);
    chk("R8 clear one channel", log_d[0], model_mask);

    // R9: request while busy is ignored
    stall_n = 2; log_n = 0;
    do_start(); cyc(2);
    term_chan_i = 2'd0; term_50_i = 1'b0; term_req_i = 1'b1;
    @(negedge clk); term_req_i = 1'b0;
    wait_idle();
    full_run_ok("R9 term during run");
    // R9: start wins over a same-cycle request
    stall_n = 0; log_n = 0;
    term_chan_i = 2'd1; term_50_i = 1'b0;
    start_i = 1'b1; term_req_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; term_req_i = 1'b0;
    wait_idle();
    full_run_ok("R9 start beats term");
    do_term(3, 1);
    chk("R9 mask unchanged", log_d[0], model_mask);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule